// File: doc/BRIEF.md
# Block Coefficient Quantizer

This block quantizes the coefficients of 8x8 transform blocks without a divider. One signed coefficient enters on each cycle that `in_valid` is high. The block multiplies its magnitude by a stored reciprocal of the quantization step, which is roughly 2^13/Q. It then rounds, shifts right by 13, restores the sign and clamps the result to the coefficient width. Sixty-four reciprocals are held in a small table, one for each position within the block. An internal position counter selects the entry that applies to each coefficient.

The work is split into a fixed four-stage pipeline. The first stage captures the coefficient's sign, its magnitude and its table entry. The second stage multiplies. The third stage is a timing buffer. The fourth stage rounds and saturates. A block-start pulse realigns the position counter to the start of a block. Software or an upstream controller can rewrite any table entry at any time through a write port. A write never alters a coefficient that has already been accepted.

Top module: `qnt_block_quantizer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid` is 0 and `out_coef` is 0. Every table entry resets to 8192, so each coefficient then passes through unchanged.
- R2: For a coefficient c at position p, with table entry R = table[p], the output is sign(c) * ((|c| * R + 4096) >> 13), clamped as described in R9. `in_coef` and `out_coef` are 11-bit two's complement; the table entries are 14-bit unsigned.
- R3: Rounding is symmetric about zero. Inputs c and -c give results of equal magnitude and opposite sign, unless clamping applies. A remainder of exactly one half rounds away from zero.
- R4: A coefficient accepted at clock edge n makes `out_valid` high in the cycle that follows edge n+3. Each accepted coefficient yields exactly one output, in order. A continuous input stream gives a continuous output stream.
- R5: The position advances by one on each accepted coefficient and wraps from 63 to 0.
- R6: When `in_blk_start` is high together with `in_valid`, that coefficient takes position 0. When `in_blk_start` is high without `in_valid`, the next accepted coefficient takes position 0.
- R7: When `tbl_we` is high, entry `tbl_addr` takes the value `tbl_data` at that clock edge. A coefficient accepted at the same edge still uses the old entry. Coefficients accepted at later edges use the new entry.
- R8: A table write does not change the result of a coefficient accepted at an earlier edge.
- R9: Results above 1023 are clamped to 1023, and results below -1024 are clamped to -1024.
- R10: `out_coef` is 0 in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient present this cycle |
| in_blk_start | input | 1 | Realign position to 0 |
| in_coef | input | 11 | Signed input coefficient |
| tbl_we | input | 1 | Reciprocal table write enable |
| tbl_addr | input | 6 | Table entry to write |
| tbl_data | input | 14 | Reciprocal value to write |
| out_valid | output | 1 | Quantized result present |
| out_coef | output | 11 | Signed quantized result |

## Verification
The hardest case to provoke is a table write that collides with a coefficient in the pipeline. The write can land on the same edge that captures the coefficient, or one edge later while the coefficient is already in flight. The stimulus schedules both collisions on position 0. It then starts a new block so that the rewritten entry is read back through the data path. A full 65-coefficient pass with distinct entries at positions 0 and 63 shows the wrap. Reciprocals above 8192 drive the clamp in both directions.

// File: rtl/qnt_pkg.sv
package qnt_pkg;
    localparam int QNT_COEF_W = 11;
    localparam int QNT_SHIFT  = 13;
    localparam int QNT_BLK_N  = 64;
endpackage

// File: rtl/qnt_index_ctr.sv
module qnt_index_ctr #(
    parameter int BLK_N = 64,
    localparam int IDX_W = $clog2(BLK_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             blk_start,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_N - 1);

    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        idx   = blk_start ? '0 : cnt_q;
        cnt_d = cnt_q;
        if (in_valid) begin
            cnt_d = (idx == LAST) ? '0 : idx + IDX_W'(1);
        end else if (blk_start) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !blk_start && cnt_q == LAST) |=> (cnt_q == '0));

    // R6
    start_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && blk_start) |=> (cnt_q == IDX_W'(1)));
endmodule

// File: rtl/qnt_recip_table.sv
module qnt_recip_table #(
    parameter int BLK_N   = 64,
    parameter int RECIP_W = 14,
    parameter logic [RECIP_W-1:0] RESET_VAL = '0,
    localparam int IDX_W = $clog2(BLK_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [RECIP_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [RECIP_W-1:0] rdata
);
    logic [RECIP_W-1:0] mem_d [BLK_N];
    logic [RECIP_W-1:0] mem_q [BLK_N];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
        rdata = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BLK_N; i++) mem_q[i] <= RESET_VAL;
        end else begin
            mem_q <= mem_d;
        end
    end

    // R7
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/qnt_round_sat.sv
module qnt_round_sat #(
    parameter int PROD_W = 25,
    parameter int SHIFT  = 13,
    parameter int OUT_W  = 11
) (
    input  logic             neg,
    input  logic [PROD_W-1:0] prod,
    output logic [OUT_W-1:0] res
);
    localparam int QW = PROD_W + 1 - SHIFT;
    localparam logic [QW-1:0] POS_LIM = QW'((2 ** (OUT_W - 1)) - 1);
    localparam logic [QW-1:0] NEG_LIM = QW'(2 ** (OUT_W - 1));
    localparam logic [PROD_W:0] HALF  = (PROD_W + 1)'(2 ** (SHIFT - 1));

    logic [PROD_W:0] biased;
    logic [QW-1:0]   qmag;
    logic [QW-1:0]   lim;
    logic [QW-1:0]   negv;

    always_comb begin
        biased = {1'b0, prod} + HALF;
        qmag   = biased[PROD_W:SHIFT];
        if (!neg) begin
            lim = (qmag > POS_LIM) ? POS_LIM : qmag;
        end else begin
            lim = (qmag > NEG_LIM) ? NEG_LIM : qmag;
        end
        negv = ~lim + QW'(1);
        res  = neg ? negv[OUT_W-1:0] : lim[OUT_W-1:0];
    end
endmodule

// File: rtl/qnt_block_quantizer.sv
module qnt_block_quantizer
    import qnt_pkg::*;
#(
    parameter int COEF_W = QNT_COEF_W,
    parameter int SHIFT  = QNT_SHIFT,
    parameter int BLK_N  = QNT_BLK_N,
    localparam int IDX_W   = $clog2(BLK_N),
    localparam int RECIP_W = SHIFT + 1,
    localparam int PROD_W  = COEF_W + RECIP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_blk_start,
    input  logic [COEF_W-1:0]  in_coef,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_addr,
    input  logic [RECIP_W-1:0] tbl_data,
    output logic               out_valid,
    output logic [COEF_W-1:0]  out_coef
);
    typedef struct packed {
        logic               s1_vld;
        logic               s1_neg;
        logic [COEF_W-1:0]  s1_mag;
        logic [RECIP_W-1:0] s1_rcp;
        logic               s2_vld;
        logic               s2_neg;
        logic [PROD_W-1:0]  s2_prod;
        logic               s3_vld;
        logic               s3_neg;
        logic [PROD_W-1:0]  s3_prod;
        logic               s4_vld;
        logic [COEF_W-1:0]  s4_q;
    } pipe_t;

    pipe_t              p_d, p_q;
    logic [IDX_W-1:0]   pos_idx;
    logic [RECIP_W-1:0] rcp_rd;
    logic [COEF_W-1:0]  rs_out;
    logic [2:0]         warm_d, warm_q;

    qnt_index_ctr #(.BLK_N(BLK_N)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .blk_start (in_blk_start),
        .idx       (pos_idx)
    );

    qnt_recip_table #(
        .BLK_N     (BLK_N),
        .RECIP_W   (RECIP_W),
        .RESET_VAL (RECIP_W'(2 ** SHIFT))
    ) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (pos_idx),
        .rdata (rcp_rd)
    );

    qnt_round_sat #(
        .PROD_W (PROD_W),
        .SHIFT  (SHIFT),
        .OUT_W  (COEF_W)
    ) u_rs (
        .neg  (p_q.s3_neg),
        .prod (p_q.s3_prod),
        .res  (rs_out)
    );

    always_comb begin
        p_d = p_q;
        // stage 1: capture sign, magnitude and reciprocal
        p_d.s1_vld = in_valid;
        p_d.s1_neg = in_coef[COEF_W-1];
        p_d.s1_mag = in_coef[COEF_W-1] ? (~in_coef + COEF_W'(1)) : in_coef;
        p_d.s1_rcp = rcp_rd;
        // stage 2: multiply
        p_d.s2_vld  = p_q.s1_vld;
        p_d.s2_neg  = p_q.s1_neg;
        p_d.s2_prod = PROD_W'(p_q.s1_mag) * PROD_W'(p_q.s1_rcp);
        // stage 3: buffer
        p_d.s3_vld  = p_q.s2_vld;
        p_d.s3_neg  = p_q.s2_neg;
        p_d.s3_prod = p_q.s2_prod;
        // stage 4: round, sign, clamp
        p_d.s4_vld = p_q.s3_vld;
        p_d.s4_q   = p_q.s3_vld ? rs_out : '0;

        warm_d = (warm_q == 3'd4) ? warm_q : warm_q + 3'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q    <= '0;
            warm_q <= '0;
        end else begin
            p_q    <= p_d;
            warm_q <= warm_d;
        end
    end

    assign out_valid = p_q.s4_vld;
    assign out_coef  = p_q.s4_q;

    // R4
    latency_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_coef == '0));

    // R3
    sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 3'd4 && out_valid && out_coef != '0)
            |-> (out_coef[COEF_W-1] == $past(in_coef[COEF_W-1], 4)));
endmodule

// File: tb/qnt_block_quantizer_test.sv
module qnt_block_quantizer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_blk_start, tbl_we;
    logic [10:0] in_coef;
    logic [5:0]  tbl_addr;
    logic [13:0] tbl_data;
    logic        out_valid;
    logic [10:0] out_coef;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    int    exp_val[$];
    string exp_tag[$];
    logic [3:0] vhist;

    // {reciprocal, coefficient, expected}
    localparam int VEC_N = 16;
    localparam int VEC [VEC_N][3] = '{
        '{8192,   100,   100}, '{8192,  -100,  -100},
        '{512,    100,     6}, '{512,   -100,    -6},
        '{512,      8,     1}, '{512,     -8,    -1},
        '{512,      7,     0}, '{512,     -7,     0},
        '{16383, 1000,  1023}, '{16383, -1000, -1024},
        '{8192, -1024, -1024}, '{8192,  1023,  1023},
        '{81,     500,     5}, '{81,    -500,    -5},
        '{1,     1023,     0}, '{0,     -300,     0}
    };

    always #5 clk = ~clk;

    qnt_block_quantizer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_blk_start (in_blk_start),
        .in_coef      (in_coef),
        .tbl_we       (tbl_we),
        .tbl_addr     (tbl_addr),
        .tbl_data     (tbl_data),
        .out_valid    (out_valid),
        .out_coef     (out_coef)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int qmodel(input int c, input int r);
        longint m, q;
        m = (c < 0) ? -c : c;
        q = (m * r + 4096) >>> 13;
        if (c < 0) return (q > 1024) ? -1024 : -int'(q);
        return (q > 1023) ? 1023 : int'(q);
    endfunction

    task automatic cyc(input logic v, input logic bs, input int c,
                       input logic we, input int wa, input int wd,
                       input int expv, input string tag);
        in_valid     = v;
        in_blk_start = bs;
        in_coef      = 11'(c);
        tbl_we       = we;
        tbl_addr     = 6'(wa);
        tbl_data     = 14'(wd);
        if (v) begin
            exp_val.push_back(expv);
            exp_tag.push_back(tag);
        end
        @(posedge clk);
        #1;
        in_valid     = 1'b0;
        in_blk_start = 1'b0;
        tbl_we       = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 1'b0, 0, 0, 0, "");
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) vhist <= '0;
        else        vhist <= {vhist[2:0], in_valid};
    end

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(out_valid === vhist[3], "R4 valid timing", int'(out_valid), int'(vhist[3]));
            if (out_valid === 1'b1) begin
                if (exp_val.size() == 0) begin
                    chk(1'b0, "R4 unexpected output", int'($signed(out_coef)), 0);
                end else begin
                    int    e;
                    string t;
                    e = exp_val.pop_front();
                    t = exp_tag.pop_front();
                    chk(int'($signed(out_coef)) == e, t, int'($signed(out_coef)), e);
                end
            end else begin
                chk(out_coef === '0, "R10 idle data", int'($signed(out_coef)), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_blk_start = 1'b0; in_coef = '0;
        tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(out_coef === '0, "R1 reset data", int'($signed(out_coef)), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1: reset table passes values through
        cyc(1'b1, 1'b1, 37, 1'b0, 0, 0, 37, "R1 reset table");
        cyc(1'b1, 1'b0, -37, 1'b0, 0, 0, -37, "R1 reset table");
        idle(6);

        // vector table: R2, R3, R9
        for (int i = 0; i < VEC_N; i++) cyc(1'b0, 1'b0, 0, 1'b1, i, VEC[i][0], 0, "");
        for (int i = 0; i < VEC_N; i++)
            cyc(1'b1, (i == 0), VEC[i][1], 1'b0, 0, 0, VEC[i][2], "R2 R3 R9 vector");
        idle(6);

        // R5: full block with distinct ends, then wrap
        cyc(1'b0, 1'b0, 0, 1'b1, 0, 256, 0, "");
        cyc(1'b0, 1'b0, 0, 1'b1, 63, 512, 0, "");
        for (int k = 0; k < 64; k++) begin
            int r;
            r = (k == 0) ? 256 : (k == 63) ? 512 : (k < VEC_N) ? VEC[k][0] : 8192;
            cyc(1'b1, (k == 0), 64, 1'b0, 0, 0, qmodel(64, r), "R5 block pass");
        end
        cyc(1'b1, 1'b0, 64, 1'b0, 0, 0, 2, "R5 wrap to 0");
        cyc(1'b1, 1'b0, 64, 1'b0, 0, 0, 64, "R5 after wrap");
        cyc(1'b1, 1'b0, 64, 1'b0, 0, 0, 4, "R5 after wrap");
        // R6: start with and without valid
        cyc(1'b1, 1'b1, 64, 1'b0, 0, 0, 2, "R6 start with valid");
        cyc(1'b1, 1'b0, 64, 1'b0, 0, 0, 64, "R6 follows start");
        cyc(1'b0, 1'b1, 0, 1'b0, 0, 0, 0, "");
        idle(2);
        cyc(1'b1, 1'b0, 64, 1'b0, 0, 0, 2, "R6 start without valid");
        cyc(1'b1, 1'b0, 64, 1'b0, 0, 0, 64, "R6 follows start");
        idle(6);

        // R7 and R8: write collisions on position 0 (entry holds 256)
        cyc(1'b1, 1'b1, 80, 1'b1, 0, 1024, 3, "R7 R8 same-edge write");
        cyc(1'b0, 1'b0, 0, 1'b1, 0, 0, 0, "");
        cyc(1'b1, 1'b1, 80, 1'b0, 0, 0, 0, "R7 new entry used");
        cyc(1'b1, 1'b1, -80, 1'b0, 0, 0, 0, "R7 new entry used");
        idle(8);
        chk(exp_val.size() == 0, "R4 outputs outstanding", exp_val.size(), 0);

        // R1: reset with data in flight clears pipeline and table
        cyc(1'b1, 1'b1, 50, 1'b0, 0, 0, 0, "");
        cyc(1'b1, 1'b0, 50, 1'b0, 0, 0, 0, "");
        rst_n = 1'b0;
        exp_val.delete();
        exp_tag.delete();
        #2;
        chk(out_valid === 1'b0, "R1 reset in flight", int'(out_valid), 0);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 50, 1'b0, 0, 0, 50, "R1 table restored");
        idle(8);
        chk(exp_val.size() == 0, "R4 outputs outstanding", exp_val.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule